// File: doc/BRIEF.md
# Variable-Size Cyclic Lane Rotator

This block is the data-alignment stage of a reconfigurable quasi-cyclic LDPC decoder. It takes `LANES` lanes of `WIDTH` bits, one lane per row of the largest supported circulant. It rotates the lowest `zsize` lanes cyclically so that the soft values match the permutation of the next non-zero submatrix in the same base-matrix column. Lanes at `zsize` and above are not part of the active circulant. They pass through on their own lane.

The caller presents the active circulant size and the two permutation factors that bracket the move: the factor already applied and the factor needed next. The block forms the rotation amount modulo `zsize` internally, using a compare and a conditional add rather than a divider. A zero-submatrix entry must never be turned into a rotation. Such a cycle is flagged with `bypass`, and the data then passes through unrotated.

The circulant size may differ on every cycle, for example between code blocks, and the datapath is the same for every size. It does not have to be a power of two. An optional output register with a clock enable closes the stage.

Top module: `qc_cyclic_shifter`

## Requirements
- R1: With `zsize` equal to `LANES` and `bypass` low, output lane n carries input lane (n + c) mod `LANES`. Lane n occupies bits [n*WIDTH +: WIDTH] of `din` and `dout`.
- R2: For any `zsize` p from 1 to `LANES`, with `bypass` low, each output lane n < p carries input lane (n + c) mod p. This covers sizes that are not powers of two.
- R3: The rotation amount is c = (`shift_new` - `shift_old`) mod p. Both factors must lie in 0..p-1. When `shift_new` is below `shift_old`, p is added.
- R4: Each output lane n with n >= p carries input lane n unchanged.
- R5: While `bypass` is high, every output lane n carries input lane n, whatever the values of `zsize`, `shift_old` and `shift_new`.
- R6: With `OUT_REG`=1, `dout` shows the result of the inputs sampled at a rising clock edge where `en` is high. When `en` is low at an edge, `dout` holds its value.
- R7: An active-low `rst_n` clears `dout` to all zeros at once, without waiting for a clock edge.
- R8: `zsize` and the factors may change on every consecutive enabled edge, with no idle cycle, and each result is correct for its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output register |
| zsize | input | $clog2(LANES+1) | Active circulant size p, 1..LANES |
| shift_old | input | $clog2(LANES+1) | Permutation factor already applied, 0..p-1 |
| shift_new | input | $clog2(LANES+1) | Permutation factor needed next, 0..p-1 |
| bypass | input | 1 | Zero-submatrix cycle: pass data unrotated |
| din | input | LANES*WIDTH | Input lanes, lane n at bits [n*WIDTH +: WIDTH] |
| dout | output | LANES*WIDTH | Rotated lanes |

## Verification
On every cycle the assertions check several behaviours. They check that lanes at or above the active size pass straight through and that bypass is a pure pass-through. They check that the internal rotation amount is below p and congruent to the difference of the factors. They check that output lane 0 is taken from input lane c, and that the register loads or holds according to the enable. Only the bench's scenarios show that every active lane lands in its wrapped position for each size from 1 to `LANES`. The same holds for back-to-back size changes and for the asynchronous clear between edges. These are compared against an independent lane model.

// File: rtl/qc_shift_pkg.sv
package qc_shift_pkg;
  typedef enum logic {
    ROT_TOWARD_LOW  = 1'b0,
    ROT_TOWARD_HIGH = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/qc_shift_amount.sv
module qc_shift_amount #(
  parameter int LANES = 96,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [CW-1:0] zsize,
  input  logic [CW-1:0] shift_old,
  input  logic [CW-1:0] shift_new,
  input  logic          bypass,
  output logic [CW-1:0] amt_fwd,
  output logic [CW-1:0] amt_back
);
  logic [CW-1:0] diff;

  always_comb begin
    diff = shift_new - shift_old;
    if (bypass) begin
      amt_fwd = '0;
    end else if (shift_new >= shift_old) begin
      amt_fwd = diff;
    end else begin
      amt_fwd = diff + zsize;
    end
    amt_back = zsize - amt_fwd;
  end
endmodule

// File: rtl/qc_barrel_rot.sv
module qc_barrel_rot
  import qc_shift_pkg::*;
#(
  parameter int       LANES = 96,
  parameter int       WIDTH = 8,
  parameter int       AW    = 7,
  parameter rot_dir_e DIR   = ROT_TOWARD_LOW,
  localparam int TOT = LANES * WIDTH
) (
  input  logic [TOT-1:0] din,
  input  logic [AW-1:0]  amt,
  output logic [TOT-1:0] dout
);
  logic [TOT-1:0] stg [AW+1];

  always_comb begin
    stg[0] = din;
    for (int k = 0; k < AW; k++) begin
      for (int n = 0; n < LANES; n++) begin
        int step;
        int src;
        step = (1 << k) % LANES;
        if (DIR == ROT_TOWARD_LOW) src = (n + step) % LANES;
        else                       src = (n + LANES - step) % LANES;
        if (amt[k]) stg[k+1][n*WIDTH +: WIDTH] = stg[k][src*WIDTH +: WIDTH];
        else        stg[k+1][n*WIDTH +: WIDTH] = stg[k][n*WIDTH +: WIDTH];
      end
    end
    dout = stg[AW];
  end
endmodule

// File: rtl/qc_lane_merge.sv
module qc_lane_merge #(
  parameter int LANES = 96,
  parameter int WIDTH = 8,
  localparam int CW  = $clog2(LANES + 1),
  localparam int TOT = LANES * WIDTH
) (
  input  logic [TOT-1:0] din,
  input  logic [TOT-1:0] rot_low,
  input  logic [TOT-1:0] rot_high,
  input  logic [CW-1:0]  zsize,
  input  logic [CW-1:0]  amt_fwd,
  output logic [TOT-1:0] dout
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    localparam logic [CW:0] LN = (CW+1)'(n);
    logic outside;
    logic no_wrap;
    assign outside = LN >= {1'b0, zsize};
    assign no_wrap = (LN + {1'b0, amt_fwd}) < {1'b0, zsize};
    assign dout[n*WIDTH +: WIDTH] = outside ? din[n*WIDTH +: WIDTH]
                                  : no_wrap ? rot_low[n*WIDTH +: WIDTH]
                                  : rot_high[n*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/qc_cyclic_shifter.sv
module qc_cyclic_shifter
  import qc_shift_pkg::*;
#(
  parameter int LANES   = 96,
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int CW  = $clog2(LANES + 1),
  localparam int TOT = LANES * WIDTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [CW-1:0]  zsize,
  input  logic [CW-1:0]  shift_old,
  input  logic [CW-1:0]  shift_new,
  input  logic           bypass,
  input  logic [TOT-1:0] din,
  output logic [TOT-1:0] dout
);
  logic [CW-1:0]  rot_fwd;
  logic [CW-1:0]  rot_back;
  logic [TOT-1:0] rot_l;
  logic [TOT-1:0] rot_r;
  logic [TOT-1:0] rot_data;

  qc_shift_amount #(.LANES(LANES)) u_amt (
    .zsize    (zsize),
    .shift_old(shift_old),
    .shift_new(shift_new),
    .bypass   (bypass),
    .amt_fwd  (rot_fwd),
    .amt_back (rot_back)
  );

  qc_barrel_rot #(.LANES(LANES), .WIDTH(WIDTH), .AW(CW), .DIR(ROT_TOWARD_LOW)) u_rot_low (
    .din (din),
    .amt (rot_fwd),
    .dout(rot_l)
  );

  qc_barrel_rot #(.LANES(LANES), .WIDTH(WIDTH), .AW(CW), .DIR(ROT_TOWARD_HIGH)) u_rot_high (
    .din (din),
    .amt (rot_back),
    .dout(rot_r)
  );

  qc_lane_merge #(.LANES(LANES), .WIDTH(WIDTH)) u_merge (
    .din     (din),
    .rot_low (rot_l),
    .rot_high(rot_r),
    .zsize   (zsize),
    .amt_fwd (rot_fwd),
    .dout    (rot_data)
  );

  if (OUT_REG) begin : g_oreg
    logic [TOT-1:0] dout_q;
    logic [TOT-1:0] dout_nxt;

    always_comb begin
      dout_nxt = dout_q;
      if (en) dout_nxt = rot_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else        dout_q <= dout_nxt;
    end

    assign dout = dout_q;
  end else begin : g_ocomb
    assign dout = rot_data;
  end
endmodule

// File: rtl/qc_cyclic_shifter_chk.sv
module qc_cyclic_shifter_chk #(
  parameter int LANES   = 96,
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int CW  = $clog2(LANES + 1),
  localparam int TOT = LANES * WIDTH
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [CW-1:0]  zsize,
  input logic [CW-1:0]  shift_old,
  input logic [CW-1:0]  shift_new,
  input logic           bypass,
  input logic [TOT-1:0] din,
  input logic [TOT-1:0] rot,
  input logic [CW-1:0]  c,
  input logic [TOT-1:0] dout
);
  logic past_ok;
  logic legal;
  logic [WIDTH-1:0] din_l [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    for (int n = 0; n < LANES; n++) din_l[n] = din[n*WIDTH +: WIDTH];
  end

  assign legal = !bypass && (zsize != '0) && ({1'b0, zsize} <= (CW+1)'(LANES))
                 && (shift_old < zsize) && (shift_new < zsize);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    // R4
    lane_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(n) >= zsize) |-> (rot[n*WIDTH +: WIDTH] == din[n*WIDTH +: WIDTH]));
  end

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (rot == din));

  // R3
  amt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (c < zsize));

  // R3
  amt_congruent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> ((({1'b0, c} + {1'b0, shift_old}) == {1'b0, shift_new}) ||
               (({1'b0, c} + {1'b0, shift_old}) == ({1'b0, shift_new} + {1'b0, zsize}))));

  // R2
  lane0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && (int'(c) < LANES)) |-> (rot[WIDTH-1:0] == din_l[c]));

  if (OUT_REG) begin : g_reg
    // R6
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(en)) |-> (dout == $past(rot)));
    // R6
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(en)) |-> $stable(dout));
  end else begin : g_comb
    // R6
    comb_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout == rot);
  end
endmodule

bind qc_cyclic_shifter qc_cyclic_shifter_chk #(
  .LANES(LANES), .WIDTH(WIDTH), .OUT_REG(OUT_REG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .zsize    (zsize),
  .shift_old(shift_old),
  .shift_new(shift_new),
  .bypass   (bypass),
  .din      (din),
  .rot      (rot_data),
  .c        (rot_fwd),
  .dout     (dout)
);

// File: tb/tb_qc_cyclic_shifter.sv
module tb_qc_cyclic_shifter;
  localparam int LANES = 96;
  localparam int WIDTH = 8;
  localparam int CW    = $clog2(LANES + 1);
  localparam int TOT   = LANES * WIDTH;
  localparam int NV    = 12;

  // p, shift_old, shift_new, bypass, expected rotation
  localparam int VP [NV] = '{96, 96, 96, 96, 24, 24, 52, 37,  1, 64,  90, 73};
  localparam int VO [NV] = '{10, 50,  0, 95,  3, 20, 51,  0,  0,  7, 127, 72};
  localparam int VN [NV] = '{30,  5,  0,  0, 20,  3,  0, 36,  0,  7, 127, 71};
  localparam int VB [NV] = '{ 0,  0,  0,  0,  0,  0,  0,  0,  0,  0,   1,  0};
  localparam int VC [NV] = '{20, 51,  0,  1, 17,  7,  1, 36,  0,  0,   0, 72};

  logic           clk;
  logic           rst_n;
  logic           en;
  logic [CW-1:0]  zsize;
  logic [CW-1:0]  shift_old;
  logic [CW-1:0]  shift_new;
  logic           bypass;
  logic [TOT-1:0] din;
  logic [TOT-1:0] dout;

  int  checks;
  int  errors;
  bit  done;

  qc_cyclic_shifter #(.LANES(LANES), .WIDTH(WIDTH), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .zsize(zsize),
    .shift_old(shift_old), .shift_new(shift_new), .bypass(bypass),
    .din(din), .dout(dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [TOT-1:0] model(input logic [TOT-1:0] d, input int p,
                                          input int c, input bit byp);
    logic [TOT-1:0] r;
    for (int n = 0; n < LANES; n++) begin
      int src;
      if (byp || n >= p) src = n;
      else               src = (n + c) % p;
      r[n*WIDTH +: WIDTH] = d[src*WIDTH +: WIDTH];
    end
    return r;
  endfunction

  function automatic logic [TOT-1:0] pattern(input int base);
    logic [TOT-1:0] r;
    for (int n = 0; n < LANES; n++) r[n*WIDTH +: WIDTH] = WIDTH'(n ^ base);
    return r;
  endfunction

  task automatic check(input logic [TOT-1:0] exp, input string tag);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, dout, exp);
    end
  endtask

  task automatic apply(input int p, input int ho, input int hn, input bit byp,
                       input int c, input string tag);
    logic [TOT-1:0] exp;
    @(negedge clk);
    zsize = CW'(p); shift_old = CW'(ho); shift_new = CW'(hn); bypass = byp;
    din = pattern(int'($urandom % 256));
    en = 1'b1;
    exp = model(din, p, c, byp);
    @(negedge clk);
    check(exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TOT-1:0] exp_q;
    logic [TOT-1:0] held;
    bit             have_exp;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b0; bypass = 1'b0;
    zsize = CW'(LANES); shift_old = '0; shift_new = '0;
    din = pattern(8'h5a);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check('0, "R7 reset");
    rst_n = 1'b1;

    // R8: table walked back to back, one new vector on every enabled edge
    have_exp = 1'b0;
    exp_q = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (have_exp) check(exp_q, $sformatf("R8 R2 R3 R4 R5 vector %0d", i - 1));
      zsize = CW'(VP[i]); shift_old = CW'(VO[i]); shift_new = CW'(VN[i]);
      bypass = VB[i][0]; en = 1'b1;
      din = pattern(i * 37 + 3);
      exp_q = model(din, VP[i], VC[i], VB[i][0]);
      have_exp = 1'b1;
    end
    @(negedge clk);
    check(exp_q, "R8 R2 R3 vector 11");

    // R1 R2 R3 R4: every size with random factors
    for (int p = 1; p <= LANES; p++) begin
      for (int k = 0; k < 4; k++) begin
        int ho;
        int hn;
        ho = int'($urandom % p);
        hn = int'($urandom % p);
        apply(p, ho, hn, 1'b0, (hn - ho + p) % p,
              (p == LANES) ? "R1 R3 full size" : "R2 R3 R4 partial size");
      end
    end

    // R1 corner: largest rotation in full mode
    apply(LANES, 0, LANES - 1, 1'b0, LANES - 1, "R1 max rotation");
    // R2 corner: wrap one below
    apply(53, 1, 0, 1'b0, 52, "R2 wrap to p-1");
    // R5: bypass with garbage factors and a small size
    apply(5, 127, 3, 1'b1, 0, "R5 bypass");

    // R6: enable low holds the output
    @(negedge clk);
    held = dout;
    en = 1'b0;
    din = pattern(8'hc3);
    zsize = CW'(17); shift_old = '0; shift_new = CW'(9); bypass = 1'b0;
    repeat (2) @(negedge clk);
    check(held, "R6 hold with enable low");

    // R7: asynchronous clear between edges
    #3;
    rst_n = 1'b0;
    #1;
    check('0, "R7 async clear");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule